// File: doc/BRIEF.md
# PWM Shared Clock-Enable Generator

This block turns one master clock into a bank of clock-enable strobes that several PWM channels share. A free-running binary prescaler produces eleven enables, one at each power-of-two fraction of the master rate from 1/1 to 1/1024. Two linear dividers, A and B, each pick one prescaler enable and divide it further by an 8-bit integer. That gives thirteen sources in total. Every channel has its own 4-bit source selector and gets a registered, one-cycle-wide enable.

All outputs are enables in the master clock domain and are not generated clocks. A channel counter advances on the cycles where its enable is high. Each divider holds its tap choice and its factor in shadow registers. It loads new settings only when its count wraps, or at any cycle while it is off, so a change never shortens or stretches a period that is already running.

Top module: `pwmclk_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, every `ch_en` bit is 0.
- R2: Selector code k in 0..10 gives a one-cycle enable every 2^k cycles. Counting rising edges after reset is released as E = 1, 2, ..., the enable is high after edge E when E >= 2 and (E-1) mod 2^k = 0.
- R3: Selector code 11 routes divider A and code 12 routes divider B. Codes 13, 14 and 15 hold the channel enable at 0.
- R4: A divider with tap t (0..10) and factor N (1..255) pulses once per N pulses of tap t, which is a period of 2^t*N cycles. With static settings from reset, its routed enable is high after edge E when E-2 is a positive multiple of 2^t*N.
- R5: A divider whose factor is 0, or whose tap select is 11..15, never pulses.
- R6: A factor written while a divider runs takes effect only after the divider's next pulse. The period that is in progress finishes with the old factor. Writing 0 stops the divider after that pulse.
- R7: Each channel follows its own selector code, regardless of what the other channels select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| div_a_tap | input | 4 | prescaler tap feeding divider A |
| div_a_factor | input | 8 | divide factor of divider A, 0 = off |
| div_b_tap | input | 4 | prescaler tap feeding divider B |
| div_b_factor | input | 8 | divide factor of divider B, 0 = off |
| ch_sel | input | 16 | four 4-bit source codes, channel c in bits [4c+3:4c] |
| ch_en | output | 4 | registered clock enable per channel |

## Verification
A tap enable reaches a channel two edges after the prescaler count matches: one edge for the tap register and one for the channel register. A divider adds one more edge, because it counts the registered tap and registers its own pulse. A selector change shows on the edge right after it is applied. The bench counts edges from the release of reset and drives every input at the falling edge. It compares each channel on every falling edge against a closed-form formula in that edge count, so any result that is one cycle early or late is reported. For the mid-run factor change, the bench lists the expected pulse edges by hand from the wrap rule and compares them cycle by cycle.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;
  parameter int PWMCLK_TAPS   = 11;
  parameter int PWMCLK_DIV_W  = 8;
  parameter int PWMCLK_TSEL_W = 4;
  parameter int PWMCLK_SEL_W  = 4;
  parameter int PWMCLK_NUM_CH = 4;

  // prescaler taps plus the two linear dividers
  function automatic int num_src(input int taps);
    return taps + 2;
  endfunction
endpackage

// File: rtl/pwmclk_prescaler.sv
module pwmclk_prescaler #(
  parameter int TAPS = 11
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TAPS-1:0] tap_q
);
  localparam int CW = (TAPS > 1) ? TAPS - 1 : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) tap_q[0] <= 1'b0;
    else     tap_q[0] <= 1'b1;
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap_q[k] <= 1'b0;
      else     tap_q[k] <= &cnt[k-1:0];
    end

    // a slower tap only fires together with every faster one
    p_tap_nest_r2: assert property (@(posedge clk) disable iff (rst)
      tap_q[k] |-> tap_q[k-1]);
    p_tap_gap_r2: assert property (@(posedge clk) disable iff (rst)
      tap_q[k] |=> !tap_q[k]);
  end
endmodule

// File: rtl/pwmclk_lindiv.sv
module pwmclk_lindiv #(
  parameter int TAPS   = 11,
  parameter int DIV_W  = 8,
  parameter int TSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAPS-1:0]   taps,
  input  logic [TSEL_W-1:0] tap_sel,
  input  logic [DIV_W-1:0]  factor,
  output logic              out_q
);
  localparam int PADN = 2 ** TSEL_W;

  logic [PADN-1:0]   tap_pad;
  logic [TSEL_W-1:0] sel_a;
  logic [DIV_W-1:0]  lim_a;
  logic [DIV_W-1:0]  dcnt;
  logic              tick;
  logic              last;
  logic              wrap;
  logic              idle;

  always_comb begin
    tap_pad = PADN'(taps);
    tick    = tap_pad[sel_a];
    idle    = (lim_a == '0);
    last    = !idle && (dcnt == lim_a - DIV_W'(1));
    wrap    = tick && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_a <= '0;
      lim_a <= '0;
      dcnt  <= '0;
      out_q <= 1'b0;
    end else begin
      out_q <= wrap;
      if (idle || wrap) begin
        lim_a <= factor;
        sel_a <= tap_sel;
        dcnt  <= '0;
      end else if (tick) begin
        dcnt <= dcnt + DIV_W'(1);
      end
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (dcnt < lim_a));
  p_out_from_tick_r4: assert property (@(posedge clk) disable iff (rst)
    out_q |-> $past(tick));
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    idle |=> !out_q);
  p_lim_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!idle && !tick) |=> $stable(lim_a));
endmodule

// File: rtl/pwmclk_chan_mux.sv
module pwmclk_chan_mux #(
  parameter int NSRC   = 13,
  parameter int SEL_W  = 4,
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         src,
  input  logic [NUM_CH*SEL_W-1:0] sel,
  output logic [NUM_CH-1:0]       ch_q
);
  localparam int PADS = 2 ** SEL_W;

  logic [PADS-1:0] src_pad;

  always_comb src_pad = PADS'(src);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SEL_W-1:0] sel_c;

    always_comb sel_c = sel[c*SEL_W +: SEL_W];

    always_ff @(posedge clk) begin
      if (rst) ch_q[c] <= 1'b0;
      else     ch_q[c] <= src_pad[sel_c];
    end

    p_bad_sel_r3: assert property (@(posedge clk) disable iff (rst)
      (int'(sel_c) >= NSRC) |=> !ch_q[c]);
  end
endmodule

// File: rtl/pwmclk_gen.sv
module pwmclk_gen
  import pwmclk_pkg::*;
#(
  parameter int TAPS   = PWMCLK_TAPS,
  parameter int DIV_W  = PWMCLK_DIV_W,
  parameter int TSEL_W = PWMCLK_TSEL_W,
  parameter int SEL_W  = PWMCLK_SEL_W,
  parameter int NUM_CH = PWMCLK_NUM_CH
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [TSEL_W-1:0]       div_a_tap,
  input  logic [DIV_W-1:0]        div_a_factor,
  input  logic [TSEL_W-1:0]       div_b_tap,
  input  logic [DIV_W-1:0]        div_b_factor,
  input  logic [NUM_CH*SEL_W-1:0] ch_sel,
  output logic [NUM_CH-1:0]       ch_en
);
  localparam int NSRC = num_src(TAPS);

  logic [TAPS-1:0] taps;
  logic            lin_a;
  logic            lin_b;
  logic [NSRC-1:0] src;

  pwmclk_prescaler #(.TAPS(TAPS)) u_pre (
    .clk(clk), .rst(rst), .tap_q(taps)
  );

  pwmclk_lindiv #(.TAPS(TAPS), .DIV_W(DIV_W), .TSEL_W(TSEL_W)) u_div_a (
    .clk(clk), .rst(rst), .taps(taps),
    .tap_sel(div_a_tap), .factor(div_a_factor), .out_q(lin_a)
  );

  pwmclk_lindiv #(.TAPS(TAPS), .DIV_W(DIV_W), .TSEL_W(TSEL_W)) u_div_b (
    .clk(clk), .rst(rst), .taps(taps),
    .tap_sel(div_b_tap), .factor(div_b_factor), .out_q(lin_b)
  );

  always_comb src = {lin_b, lin_a, taps};

  pwmclk_chan_mux #(.NSRC(NSRC), .SEL_W(SEL_W), .NUM_CH(NUM_CH)) u_mux (
    .clk(clk), .rst(rst), .src(src), .sel(ch_sel), .ch_q(ch_en)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (ch_en == '0));
endmodule

// File: tb/sim_pwmclk_gen.sv
`timescale 1ns/1ps
module sim_pwmclk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  div_a_tap = '0;
  logic [7:0]  div_a_factor = '0;
  logic [3:0]  div_b_tap = '0;
  logic [7:0]  div_b_factor = '0;
  logic [15:0] ch_sel = '0;
  logic [3:0]  ch_en;

  int checks = 0;
  int errors = 0;
  int E = 0;
  int sel_v[4];
  bit done = 0;

  always #5 clk = ~clk;

  pwmclk_gen u0 (
    .clk(clk), .rst(rst),
    .div_a_tap(div_a_tap), .div_a_factor(div_a_factor),
    .div_b_tap(div_b_tap), .div_b_factor(div_b_factor),
    .ch_sel(ch_sel), .ch_en(ch_en)
  );

  task automatic check(input bit got, input bit exp, input string tag, input int c);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ch%0d edge %0d: got %0b expected %0b", tag, c, E, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    E++;
  endtask

  task automatic set_sel(input int s0, input int s1, input int s2, input int s3);
    sel_v[0] = s0; sel_v[1] = s1; sel_v[2] = s2; sel_v[3] = s3;
    for (int c = 0; c < 4; c++) ch_sel[c*4 +: 4] = 4'(sel_v[c]);
  endtask

  // R1: quiet during reset
  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      for (int c = 0; c < 4; c++) check(ch_en[c], 1'b0, "R1", c);
    end
    rst = 1'b0;
    E = 0;
  endtask

  function automatic bit div_exp(input int t, input int n);
    int per;
    if (n == 0 || t > 10) return 1'b0;
    per = (1 << t) * n;
    return (E >= 2 + per) && ((E - 2) % per == 0);
  endfunction

  function automatic bit exp_of(input int c);
    int s;
    s = sel_v[c];
    if (s <= 10) return (E >= 2) && ((E - 1) % (1 << s) == 0);
    if (s == 11) return div_exp(int'(div_a_tap), int'(div_a_factor));
    if (s == 12) return div_exp(int'(div_b_tap), int'(div_b_factor));
    return 1'b0;
  endfunction

  function automatic string tag_of(input int c);
    int s;
    s = sel_v[c];
    if (s <= 10) return "R2 R7";
    if (s == 11) return (div_a_factor == 0 || div_a_tap > 10) ? "R5" : "R4";
    if (s == 12) return (div_b_factor == 0 || div_b_tap > 10) ? "R5" : "R4";
    return "R3";
  endfunction

  task automatic run_static(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      for (int c = 0; c < 4; c++) check(ch_en[c], exp_of(c), tag_of(c), c);
    end
  endtask

  function automatic bit in_list(input int e);
    int lst[8] = '{6, 10, 14, 20, 26, 32, 38, 44};
    foreach (lst[i]) if (lst[i] == e) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    // tap sweep, dividers A (t1,N3) and B (t0,N5), and codes 13..15
    div_a_tap = 4'd1; div_a_factor = 8'd3;
    div_b_tap = 4'd0; div_b_factor = 8'd5;
    for (int g = 0; g < 4; g++) begin
      set_sel(4*g, 4*g + 1, 4*g + 2, 4*g + 3);
      do_reset();
      run_static(2100);
    end

    // divider ranges: R4
    div_a_tap = 4'd2; div_a_factor = 8'd1;
    div_b_tap = 4'd0; div_b_factor = 8'd255;
    set_sel(11, 12, 12, 11);
    do_reset();
    run_static(1100);

    div_a_tap = 4'd10; div_a_factor = 8'd2;
    div_b_tap = 4'd3;  div_b_factor = 8'd7;
    set_sel(11, 12, 3, 10);
    do_reset();
    run_static(2100);

    // dividers off: R5
    div_a_tap = 4'd0;  div_a_factor = 8'd0;
    div_b_tap = 4'd12; div_b_factor = 8'd3;
    set_sel(11, 12, 0, 5);
    do_reset();
    run_static(300);

    // mid-run factor change: R6
    div_a_tap = 4'd0; div_a_factor = 8'd4;
    div_b_tap = 4'd0; div_b_factor = 8'd0;
    set_sel(11, 11, 0, 12);
    do_reset();
    for (int i = 0; i < 80; i++) begin
      step();
      check(ch_en[0], in_list(E), "R6", 0);
      check(ch_en[1], in_list(E), "R6", 1);
      check(ch_en[2], (E >= 2), "R2 R7", 2);
      check(ch_en[3], 1'b0, "R5", 3);
      if (E == 11) div_a_factor = 8'd6;
      if (E == 41) div_a_factor = 8'd0;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule